// File: doc/BRIEF.md
# Nested Vectored Priority Interrupt Controller

The controller collects requests from a set of interrupt and trap sources, each with a fixed priority level, and presents one winner to the processor together with the address of that source's vector. Vector entries are two bytes wide and sit in a table at a fixed base. Each source has a pending flag. The flag is set while the source is high and stays set until the handler clears it explicitly, so a condition that is still active cannot be lost.

Nested servicing relies on an in-service record with one bit per priority level. Accepting a request sets the bit for the winner's level and closes the global enable. The handler then reopens the enable when it is ready to be preempted. A pending request is offered only when its level is strictly above the highest level still in service. An end-of-service strobe retires the highest level in the record and reopens the enable. A request is accepted only at an instruction boundary. Non-maskable sources ignore the global enable but are still subject to the in-service comparison.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A source that is high at a rising clock edge sets its pending flag. The flag stays set after the source drops, until a clear strobe names that source's index. A clear has no effect while the source is still high.
- R2: Source i has level floor(i*NUM_LVL/NUM_SRC), where a larger level is more urgent. The offered source is the eligible source with the highest level. Among equal levels, the higher index wins.
- R3: While a request is offered, the vector output equals 0xFFD6 + 2*source index. With the defaults, source 20 gives 0xFFFE.
- R4: After reset, nothing is pending, the in-service record is empty and the global enable is closed, so irq_o and svc_act_o are 0.
- R5: A maskable source is not offered while the global enable is closed. The unmask strobe opens the enable.
- R6: A take strobe is accepted only when boundary_i and irq_o are both high. Acceptance sets the record bit for the offered level and closes the global enable. A take without a boundary changes nothing.
- R7: While the record is non-empty, only sources whose level is strictly above the highest level in service are offered.
- R8: End-of-service clears the highest set record bit and opens the global enable. svc_lvl_o reports the highest remaining set bit.
- R9: Non-maskable sources (by default the two highest indices) are offered even while the global enable is closed, but they remain subject to R7.
- R10: The outputs depend only on registered state, so a change made at an edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Request lines, one per source |
| clr_i | input | 1 | Clear strobe for one pending flag |
| clr_idx_i | input | SRC_W | Index of the flag to clear |
| unmask_i | input | 1 | Opens the global enable |
| boundary_i | input | 1 | Current instruction has completed |
| take_i | input | 1 | Processor takes the offered request |
| eoi_i | input | 1 | End of service of the current handler |
| irq_o | output | 1 | A request is offered |
| src_o | output | SRC_W | Offered source index |
| vec_o | output | ADDR_W | Vector entry address of the offered source |
| svc_act_o | output | 1 | Some level is in service |
| svc_lvl_o | output | LVL_W | Highest level in service |

## Verification
A corrupted in-service record shows up at the ports within one cycle. svc_lvl_o changes, and the preemption threshold moves with it, so irq_o is raised for a request that should wait or held low for one that should preempt. A stuck or wrongly cleared pending flag shows on irq_o or src_o as soon as that source would have won arbitration, which can be many cycles after the fault if higher levels are busy. The bench therefore compares every output on every cycle with a reference model. It covers nested takes, returns, and clears issued while a source is still held high.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // fixed level of a source; larger is more urgent
  function automatic int unsigned src_level(int unsigned idx, int unsigned n_src,
                                            int unsigned n_lvl);
    return (idx * n_lvl) / n_src;
  endfunction
endpackage

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int unsigned NUM_SRC = 21,
  parameter int unsigned SRC_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_i,
  input  logic [SRC_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic clr_hit;
    assign clr_hit = clr_i && (clr_idx_i == SRC_W'(g));

    // set dominates clear: a held level is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_q[g] <= 1'b0;
      else if (src_i[g])   pend_q[g] <= 1'b1;
      else if (clr_hit)    pend_q[g] <= 1'b0;
    end

    assert_latch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_i[g] |=> pend_q[g]);
    assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[g] && !clr_hit |=> pend_q[g]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int unsigned          NUM_SRC  = 21,
  parameter int unsigned          NUM_LVL  = 8,
  parameter int unsigned          SRC_W    = 5,
  parameter int unsigned          LVL_W    = 3,
  parameter logic [NUM_SRC-1:0]   NMI_MASK = '0
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               gie_i,
  input  logic               busy_i,
  input  logic [LVL_W-1:0]   cur_lvl_i,
  output logic               valid_o,
  output logic [SRC_W-1:0]   idx_o,
  output logic [LVL_W-1:0]   lvl_o
);
  logic [LVL_W-1:0]   src_lvl [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int unsigned LV = nic_pkg::src_level(g, NUM_SRC, NUM_LVL);
    assign src_lvl[g] = LVL_W'(LV);
    assign elig[g] = pend_i[g] && (gie_i || NMI_MASK[g]) &&
                     (!busy_i || (src_lvl[g] > cur_lvl_i));
  end

  // ascending scan with >= : ties resolve to the higher index
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!valid_o || src_lvl[i] >= lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = SRC_W'(i);
        lvl_o   = src_lvl[i];
      end
    end
  end
endmodule

// File: rtl/nic_service.sv
module nic_service #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned LVL_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [LVL_W-1:0] take_lvl_i,
  input  logic             eoi_i,
  input  logic             unmask_i,
  output logic             gie_o,
  output logic             busy_o,
  output logic [LVL_W-1:0] cur_lvl_o
);
  logic [NUM_LVL-1:0] insvc_q, insvc_d, drop, add;
  logic               gie_q;

  always_comb begin
    busy_o    = |insvc_q;
    cur_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (insvc_q[l]) cur_lvl_o = LVL_W'(l);
  end

  assign drop    = (eoi_i && busy_o) ? (NUM_LVL'(1) << cur_lvl_o) : '0;
  assign add     = take_i ? (NUM_LVL'(1) << take_lvl_i) : '0;
  assign insvc_d = (insvc_q & ~drop) | add;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insvc_q <= '0;
      gie_q   <= 1'b0;
    end else begin
      insvc_q <= insvc_d;
      if (take_i)                gie_q <= 1'b0;
      else if (eoi_i || unmask_i) gie_q <= 1'b1;
    end
  end

  assign gie_o = gie_q;

  assert_mask_on_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !gie_q);
  assert_record_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> insvc_q[$past(take_lvl_i)]);
  assert_eoi_unmask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && !take_i |=> gie_q);
  assert_eoi_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && !take_i && busy_o |=> !insvc_q[$past(cur_lvl_o)]);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int unsigned        NUM_SRC  = 21,
  parameter int unsigned        NUM_LVL  = 8,
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  VEC_BASE = 16'hFFD6,
  parameter logic [NUM_SRC-1:0] NMI_MASK = {2'b11, {(NUM_SRC-2){1'b0}}},
  localparam int unsigned       SRC_W    = $clog2(NUM_SRC),
  localparam int unsigned       LVL_W    = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_i,
  input  logic [SRC_W-1:0]   clr_idx_i,
  input  logic               unmask_i,
  input  logic               boundary_i,
  input  logic               take_i,
  input  logic               eoi_i,
  output logic               irq_o,
  output logic [SRC_W-1:0]   src_o,
  output logic [ADDR_W-1:0]  vec_o,
  output logic               svc_act_o,
  output logic [LVL_W-1:0]   svc_lvl_o
);
  logic [NUM_SRC-1:0] pend;
  logic               gie, busy, win_vld, take_acc;
  logic [LVL_W-1:0]   cur_lvl, win_lvl;
  logic [SRC_W-1:0]   win_idx;

  nic_pending #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pend (
    .clk_i, .rst_ni, .src_i, .clr_i, .clr_idx_i, .pend_o(pend)
  );

  nic_arbiter #(
    .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .SRC_W(SRC_W), .LVL_W(LVL_W),
    .NMI_MASK(NMI_MASK)
  ) u_arb (
    .pend_i(pend), .gie_i(gie), .busy_i(busy), .cur_lvl_i(cur_lvl),
    .valid_o(win_vld), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  // taken only at an instruction boundary
  assign take_acc = take_i && boundary_i && win_vld;

  nic_service #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_svc (
    .clk_i, .rst_ni, .take_i(take_acc), .take_lvl_i(win_lvl), .eoi_i, .unmask_i,
    .gie_o(gie), .busy_o(busy), .cur_lvl_o(cur_lvl)
  );

  assign irq_o     = win_vld;
  assign src_o     = win_idx;
  assign vec_o     = VEC_BASE + (ADDR_W'(win_idx) << 1);
  assign svc_act_o = busy;
  assign svc_lvl_o = cur_lvl;

  assert_preempt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && svc_act_o |-> win_lvl > svc_lvl_o);
  assert_nmi_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !gie |-> NMI_MASK[src_o]);
  assert_offer_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend[src_o]);
  assert_no_take_off_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !boundary_i && !eoi_i |=>
      (svc_act_o == $past(svc_act_o)) && (svc_lvl_o == $past(svc_lvl_o)));
endmodule

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  localparam int NS = 21;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          clr, unm, bnd, tk, eo;
  logic [4:0]    cidx;
  logic          irq_o, svc_act_o;
  logic [4:0]    src_o;
  logic [15:0]   vec_o;
  logic [2:0]    svc_lvl_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [NS-1:0] m_pend;
  logic [NL-1:0] m_ins;
  bit            m_gie;

  always #5 clk = ~clk;

  nest_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .clr_i(clr), .clr_idx_i(cidx),
    .unmask_i(unm), .boundary_i(bnd), .take_i(tk), .eoi_i(eo),
    .irq_o(irq_o), .src_o(src_o), .vec_o(vec_o), .svc_act_o(svc_act_o),
    .svc_lvl_o(svc_lvl_o)
  );

  function automatic int lvl_of(int i);
    return (i * NL) / NS;
  endfunction

  function automatic int m_cur();
    int c = 0;
    for (int l = 0; l < NL; l++) if (m_ins[l]) c = l;
    return c;
  endfunction

  // returns -1 when nothing is offered
  function automatic int m_win();
    int w = -1;
    for (int i = 0; i < NS; i++) begin
      if (m_pend[i] && (m_gie || i >= NS - 2) &&
          (m_ins == 0 || lvl_of(i) > m_cur()) &&
          (w < 0 || lvl_of(i) >= lvl_of(w)))
        w = i;
    end
    return w;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int w = m_win();
    check("R7", irq_o, (w >= 0));
    if (w >= 0) begin
      check("R2", src_o, w);
      check("R3", vec_o, 16'hFFD6 + 2 * w);
    end
    check("R6", svc_act_o, (m_ins != 0));
    if (m_ins != 0) check("R8", svc_lvl_o, m_cur());
  endtask

  // drives inputs at a negedge, advances the model, checks after the edge (R10)
  task automatic cyc(logic [NS-1:0] s, bit c, int ci, bit u, bit b, bit t, bit e);
    int w = m_win();
    bit acc;
    int cur = m_cur();
    bit busy = (m_ins != 0);
    src = s; clr = c; cidx = 5'(ci); unm = u; bnd = b; tk = t; eo = e;
    acc = t && b && (w >= 0);
    for (int i = 0; i < NS; i++) begin
      if (s[i]) m_pend[i] = 1'b1;
      else if (c && ci == i) m_pend[i] = 1'b0;
    end
    if (e && busy) m_ins[cur] = 1'b0;
    if (acc) m_ins[lvl_of(w)] = 1'b1;
    if (acc) m_gie = 0;
    else if (e || u) m_gie = 1;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cyc('0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'h1F2E3D);
    rst_n = 0; src = '0; clr = 0; cidx = '0; unm = 0; bnd = 0; tk = 0; eo = 0;
    m_pend = '0; m_ins = '0; m_gie = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R4", irq_o, 0);
    check("R4", svc_act_o, 0);

    cyc(NS'(1) << 3, 0, 0, 0, 0, 0, 0);
    check("R5", irq_o, 0);                         // masked source held off
    idle();
    cyc('0, 0, 0, 1, 0, 0, 0);
    check("R5", irq_o, 1);
    check("R1", src_o, 3);                         // flag kept after source fell
    check("R3", vec_o, 16'hFFDC);
    cyc('0, 0, 0, 0, 0, 1, 0);
    check("R6", svc_act_o, 0);                     // no boundary, no take
    cyc('0, 0, 0, 0, 1, 1, 0);
    check("R6", svc_act_o, 1);
    check("R6", svc_lvl_o, 1);
    check("R6", irq_o, 0);
    cyc(NS'(1) << 20, 0, 0, 0, 0, 0, 0);
    check("R9", irq_o, 1);
    check("R9", src_o, 20);
    cyc('0, 0, 0, 0, 1, 1, 0);
    check("R8", svc_lvl_o, 7);
    cyc(NS'(1) << 19, 0, 0, 0, 0, 0, 0);
    check("R9", irq_o, 0);                         // equal level waits
    cyc('0, 0, 0, 0, 0, 0, 1);
    check("R8", svc_lvl_o, 1);
    check("R2", src_o, 20);                        // tie goes to higher index
    check("R3", vec_o, 16'hFFFE);
    cyc('0, 1, 20, 0, 0, 0, 0);
    check("R2", src_o, 19);
    cyc('0, 1, 19, 0, 0, 0, 0);
    check("R7", irq_o, 0);                         // level 1 not above level 1
    cyc(NS'(1) << 10, 0, 0, 0, 0, 0, 0);
    check("R7", irq_o, 1);
    check("R7", src_o, 10);
    cyc('0, 1, 10, 0, 0, 0, 0);
    cyc('0, 0, 0, 0, 0, 0, 1);
    check("R8", svc_act_o, 0);
    check("R8", src_o, 3);
    cyc(NS'(1) << 5, 0, 0, 0, 0, 0, 0);
    cyc(NS'(1) << 5, 1, 5, 0, 0, 0, 0);
    check("R1", src_o, 5);                         // clear ignored while held
    cyc('0, 1, 5, 0, 0, 0, 0);
    check("R1", src_o, 3);
    cyc('0, 1, 3, 0, 0, 0, 0);
    check("R1", irq_o, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [NS-1:0] s = '0;
      for (int i = 0; i < NS; i++) s[i] = ($urandom_range(0, 15) == 0);
      cyc(s, $urandom_range(0, 3) != 0, $urandom_range(0, NS - 1),
          $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1,
          $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule